// File: doc/BRIEF.md
# Shared-Bus Multi-Cycle CPU Sequencer

This block is the phase controller of a small 32-bit core with compressed-instruction support. The core owns a single AHB-Lite master port, and both instruction fetches and loads/stores go through it. The sequencer walks each instruction through a short series of phases:

- **C0** captures the fetched word.
- **C1** is an optional second fetch, used only for a 32-bit instruction that starts on an odd halfword.
- **C2** is the execute phase. It carries the address phase of a load or store.
- **C3** is the write-back phase. It completes the data transfer and issues the address phase of the next fetch.

Because the next fetch address goes out during C3, its data arrives in the next C0, and the shared port never idles between instructions.

Besides the phase, the block drives the bus request and the instruction register. It chooses which address source the datapath puts on HADDR, and drives HTRANS and HWRITE. It builds the 32-bit instruction register from the fetched halfwords. It also gives the register-file write enable, the PC advance strobe and the PC step length. The ALU, register file, decompressor and PC arithmetic sit outside and follow these controls.

Top module: `rv_bus_sequencer`

## Requirements
- R1: While `rst_n` is low, `phase` is 0 (boot) and `htrans` is IDLE (2'b00). After release, the boot phase drives a NONSEQ (2'b10) read with `addr_sel` 0 (current PC) and moves to C0 (`phase` 1) on the first cycle with `hready` high.
- R2: Phase codes are boot=0, C0=1, C1=2, C2=3, C3=4. An instruction goes C0→C2→C3→C0. C1 is inserted between C0 and C2 only when `pc_half` is 1 and `hrdata[17:16]` is 2'b11.
- R3: At the end of C0, `instr` is built from the first halfword: `hrdata[15:0]` when `pc_half` is 0, `hrdata[31:16]` when it is 1. A halfword whose low two bits are not 2'b11 is compressed: `instr_c` becomes 1, `instr[31:16]` becomes zero, and `dec_en` is high during the completing C0 cycle.
- R4: For an aligned 32-bit instruction, `instr` equals the whole C0 word. For a misaligned one, C0 issues a NONSEQ read with `addr_sel` 1 (next word, PC+4 aligned down) on its completing cycle. C1 then loads `hrdata[15:0]` into `instr[31:16]` and drives `htrans` IDLE.
- R5: In C2, a load or store drives NONSEQ with `addr_sel` 2 (data address) and `hwrite` equal to `is_store`. Otherwise `htrans` is IDLE and `hwrite` is 0.
- R6: In C3, the block drives a NONSEQ read with `addr_sel` 3 (next PC), `hwrite` 0, and `wdata_en` equal to `is_store`.
- R7: On the completing C3 cycle, `pc_adv` is 1 and `rf_we` is 1 unless the instruction is a store. `pc_len4` is 1 exactly when the instruction is 32 bits. `rf_we` and `pc_adv` are 0 in every other cycle, including all cycles before the first C3.
- R8: While `hready` is low, the phase and `instr` hold, `rf_we` and `pc_adv` stay 0, and `htrans` holds in every phase except C0. In C0, `htrans` stays IDLE until the cycle that completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hready | input | 1 | Bus ready; phase advances only when high |
| pc_half | input | 1 | PC bit 1 (instruction starts on upper halfword) |
| hrdata | input | XLEN | Bus read data |
| is_load | input | 1 | Decoded instruction is a load (C2/C3) |
| is_store | input | 1 | Decoded instruction is a store (C2/C3) |
| phase | output | 3 | Current phase code |
| addr_sel | output | 2 | HADDR source: 0 PC, 1 PC+4 word, 2 data, 3 next PC |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write flag |
| ir_lo_en | output | 1 | Instruction low-half latch enable |
| ir_hi_en | output | 1 | Instruction high-half latch enable |
| dec_en | output | 1 | Decompressor enable |
| instr | output | 32 | Assembled instruction register |
| instr_c | output | 1 | Instruction is compressed |
| wdata_en | output | 1 | Store data drive enable (HWDATA) |
| rf_we | output | 1 | Register-file write enable |
| pc_adv | output | 1 | PC advance strobe |
| pc_len4 | output | 1 | PC step is 4 (else 2) |

## Verification
Bus controls (`htrans`, `addr_sel`, `hwrite`, `wdata_en`, `rf_we`, `pc_adv`, `dec_en`) follow combinationally from the phase and that cycle's inputs, so the bench checks them in the same cycle, one time unit after driving inputs on the falling edge. The phase and `instr` are registered, so the bench checks them in the cycle after the rising edge that completed the phase: `instr` first in C2 and the new phase at the start of each visit. The sweep covers every alignment × width × access kind, with zero to two wait states in each phase. Each wait cycle is checked for hold before the completing cycle is checked.

// File: rtl/rvseq_pkg.sv
package rvseq_pkg;
   typedef enum logic [2:0] {
      PH_BOOT = 3'd0,
      PH_C0   = 3'd1,
      PH_C1   = 3'd2,
      PH_C2   = 3'd3,
      PH_C3   = 3'd4
   } phase_e;

   localparam logic [1:0] HT_IDLE   = 2'b00;
   localparam logic [1:0] HT_NONSEQ = 2'b10;

   localparam logic [1:0] AS_PC   = 2'd0;
   localparam logic [1:0] AS_PC4  = 2'd1;
   localparam logic [1:0] AS_DATA = 2'd2;
   localparam logic [1:0] AS_NEXT = 2'd3;

   localparam int HALF_W = 16;
endpackage

// File: rtl/rvseq_phase_fsm.sv
module rvseq_phase_fsm
   import rvseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   hready,
   input  logic   need_c1,
   output phase_e phase
);
   phase_e nxt;

   always_comb begin
      nxt = phase;
      case (phase)
         PH_BOOT: nxt = PH_C0;
         PH_C0:   nxt = need_c1 ? PH_C1 : PH_C2;
         PH_C1:   nxt = PH_C2;
         PH_C2:   nxt = PH_C3;
         PH_C3:   nxt = PH_C0;
         default: nxt = PH_BOOT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      phase <= PH_BOOT;
      else if (hready) phase <= nxt;
   end
endmodule

// File: rtl/rvseq_fetch_align.sv
module rvseq_fetch_align
   import rvseq_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hready,
   input  phase_e          phase,
   input  logic            pc_half,
   input  logic [XLEN-1:0] hrdata,
   output logic            need_c1,
   output logic            ir_lo_en,
   output logic            ir_hi_en,
   output logic            dec_en,
   output logic [31:0]     instr,
   output logic            instr_c
);
   localparam int NHALF = XLEN / HALF_W;

   logic [HALF_W-1:0] hw [NHALF];
   logic [HALF_W-1:0] first_hw;
   logic [HALF_W-1:0] hi_next;
   logic              first_c;
   logic              c0_done;
   logic              c1_done;
   logic [HALF_W-1:0] ir_lo;
   logic [HALF_W-1:0] ir_hi;

   genvar g;
   generate
      for (g = 0; g < NHALF; g++) begin : g_lane
         assign hw[g] = hrdata[g*HALF_W +: HALF_W];
      end
   endgenerate

   assign first_hw = pc_half ? hw[1] : hw[0];
   assign first_c  = (first_hw[1:0] != 2'b11);
   assign c0_done  = (phase == PH_C0) && hready;
   assign c1_done  = (phase == PH_C1) && hready;
   assign need_c1  = (phase == PH_C0) && pc_half && !first_c;

   assign ir_lo_en = c0_done;
   assign ir_hi_en = c0_done || c1_done;
   assign dec_en   = c0_done && first_c;

   always_comb begin
      if (c1_done)                   hi_next = hw[0];
      else if (!pc_half && !first_c) hi_next = hw[1];
      else                           hi_next = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_lo   <= '0;
         ir_hi   <= '0;
         instr_c <= 1'b0;
      end else begin
         if (ir_lo_en) begin
            ir_lo   <= first_hw;
            instr_c <= first_c;
         end
         if (ir_hi_en) ir_hi <= hi_next;
      end
   end

   assign instr = {ir_hi, ir_lo};
endmodule

// File: rtl/rvseq_bus_ctl.sv
module rvseq_bus_ctl
   import rvseq_pkg::*;
#(
   parameter bit WB_ON_STORE = 1'b0
)(
   input  logic       rst_n,
   input  logic       hready,
   input  phase_e     phase,
   input  logic       need_c1,
   input  logic       is_load,
   input  logic       is_store,
   output logic [1:0] htrans,
   output logic [1:0] addr_sel,
   output logic       hwrite,
   output logic       wdata_en,
   output logic       rf_we,
   output logic       pc_adv
);
   logic wb_ok;

   generate
      if (WB_ON_STORE) begin : g_wb_all
         assign wb_ok = 1'b1;
      end else begin : g_wb_nostore
         assign wb_ok = !is_store;
      end
   endgenerate

   always_comb begin
      htrans   = HT_IDLE;
      addr_sel = AS_PC;
      hwrite   = 1'b0;
      wdata_en = 1'b0;
      rf_we    = 1'b0;
      pc_adv   = 1'b0;
      if (rst_n) begin
         case (phase)
            PH_BOOT: htrans = HT_NONSEQ;
            PH_C0: begin
               if (need_c1 && hready) begin
                  htrans   = HT_NONSEQ;
                  addr_sel = AS_PC4;
               end
            end
            PH_C2: begin
               if (is_load || is_store) begin
                  htrans   = HT_NONSEQ;
                  addr_sel = AS_DATA;
                  hwrite   = is_store;
               end
            end
            PH_C3: begin
               htrans   = HT_NONSEQ;
               addr_sel = AS_NEXT;
               wdata_en = is_store;
               pc_adv   = hready;
               rf_we    = hready && wb_ok;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rv_bus_sequencer.sv
module rv_bus_sequencer
   import rvseq_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit WB_ON_STORE = 1'b0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hready,
   input  logic            pc_half,
   input  logic [XLEN-1:0] hrdata,
   input  logic            is_load,
   input  logic            is_store,
   output logic [2:0]      phase,
   output logic [1:0]      addr_sel,
   output logic [1:0]      htrans,
   output logic            hwrite,
   output logic            ir_lo_en,
   output logic            ir_hi_en,
   output logic            dec_en,
   output logic [31:0]     instr,
   output logic            instr_c,
   output logic            wdata_en,
   output logic            rf_we,
   output logic            pc_adv,
   output logic            pc_len4
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("rv_bus_sequencer: XLEN must be 32");
      end
   endgenerate

   phase_e ph;
   logic   need_c1;

   rvseq_phase_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .hready  (hready),
      .need_c1 (need_c1),
      .phase   (ph)
   );

   rvseq_fetch_align #(.XLEN(XLEN)) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .hready   (hready),
      .phase    (ph),
      .pc_half  (pc_half),
      .hrdata   (hrdata),
      .need_c1  (need_c1),
      .ir_lo_en (ir_lo_en),
      .ir_hi_en (ir_hi_en),
      .dec_en   (dec_en),
      .instr    (instr),
      .instr_c  (instr_c)
   );

   rvseq_bus_ctl #(.WB_ON_STORE(WB_ON_STORE)) u_bus (
      .rst_n    (rst_n),
      .hready   (hready),
      .phase    (ph),
      .need_c1  (need_c1),
      .is_load  (is_load),
      .is_store (is_store),
      .htrans   (htrans),
      .addr_sel (addr_sel),
      .hwrite   (hwrite),
      .wdata_en (wdata_en),
      .rf_we    (rf_we),
      .pc_adv   (pc_adv)
   );

   assign phase   = ph;
   assign pc_len4 = !instr_c;
endmodule

// File: rtl/rvseq_checker.sv
module rvseq_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        hready,
   input logic        pc_half,
   input logic [1:0]  hi_code,
   input logic        is_load,
   input logic        is_store,
   input logic [2:0]  phase,
   input logic [1:0]  htrans,
   input logic        hwrite,
   input logic [31:0] instr,
   input logic        rf_we,
   input logic        pc_adv
);
   // R1: boot phase hands over to C0
   p_boot_to_c0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd0 && hready) |=> (phase == 3'd1));

   // R2: C1 only for a misaligned 32-bit instruction
   p_c1_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd1 && hready && pc_half && hi_code == 2'b11) |=> (phase == 3'd2));
   p_c1_skipped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd1 && hready && !(pc_half && hi_code == 2'b11)) |=> (phase == 3'd3));
   p_c3_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd4 && hready) |=> (phase == 3'd1));

   // R5: write only in C2 for a store
   p_hwrite_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hwrite |-> (is_store && phase == 3'd3));
   p_c2_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd3 && !is_load && !is_store) |-> (htrans == 2'b00));

   // R7: write-back and PC advance only on a completing C3
   p_rf_we_c3_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (phase == 3'd4 && hready && !is_store));
   p_pc_adv_c3_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_adv |-> (phase == 3'd4 && hready));

   // R8: wait states hold phase, instruction and non-C0 transfer type
   p_hold_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> $stable(phase));
   p_hold_instr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> $stable(instr));
   p_hold_htrans_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && phase != 3'd1) |=> $stable(htrans));
endmodule

bind rv_bus_sequencer rvseq_checker i_rvseq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .hready   (hready),
   .pc_half  (pc_half),
   .hi_code  (hrdata[17:16]),
   .is_load  (is_load),
   .is_store (is_store),
   .phase    (phase),
   .htrans   (htrans),
   .hwrite   (hwrite),
   .instr    (instr),
   .rf_we    (rf_we),
   .pc_adv   (pc_adv)
);

// File: tb/test_rv_bus_sequencer.sv
`timescale 1ns/1ps
module test_rv_bus_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hready = 1'b0;
   logic        pc_half = 1'b0;
   logic [31:0] hrdata = '0;
   logic        is_load = 1'b0;
   logic        is_store = 1'b0;
   logic [2:0]  phase;
   logic [1:0]  addr_sel, htrans;
   logic        hwrite, ir_lo_en, ir_hi_en, dec_en, instr_c;
   logic [31:0] instr;
   logic        wdata_en, rf_we, pc_adv, pc_len4;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rv_bus_sequencer i_rv_bus_sequencer (
      .clk(clk), .rst_n(rst_n), .hready(hready), .pc_half(pc_half),
      .hrdata(hrdata), .is_load(is_load), .is_store(is_store),
      .phase(phase), .addr_sel(addr_sel), .htrans(htrans), .hwrite(hwrite),
      .ir_lo_en(ir_lo_en), .ir_hi_en(ir_hi_en), .dec_en(dec_en),
      .instr(instr), .instr_c(instr_c), .wdata_en(wdata_en),
      .rf_we(rf_we), .pc_adv(pc_adv), .pc_len4(pc_len4)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   // drive one cycle's inputs on the falling edge, settle, return for checking
   task automatic drive(input bit rdy, input logic [31:0] d);
      @(negedge clk);
      hready = rdy;
      hrdata = d;
      #1;
   endtask

   task automatic run_instr(input bit ph, input bit i32, input bit ld, input bit st,
                            input int waits, input logic [31:0] seed);
      logic [31:0] w1, w2, exp_i;
      bit need;
      w1 = seed;
      w2 = ~seed;
      if (!ph) w1[1:0]   = i32 ? 2'b11 : 2'b01;
      else     w1[17:16] = i32 ? 2'b11 : 2'b10;
      need = ph && i32;
      if (!ph) exp_i = i32 ? w1 : {16'h0, w1[15:0]};
      else     exp_i = i32 ? {w2[15:0], w1[31:16]} : {16'h0, w1[31:16]};
      pc_half = ph;
      // C0
      for (int i = 0; i < waits; i++) begin
         drive(1'b0, 32'hFFFF_FFFF);
         eq("R8 C0 wait phase", {29'd0, phase}, 32'd1);
         eq("R8 C0 wait htrans", {30'd0, htrans}, 32'd0);
         eq("R8 C0 wait rf_we", {31'd0, rf_we}, 32'd0);
      end
      drive(1'b1, w1);
      eq("R2 C0 phase", {29'd0, phase}, 32'd1);
      eq("R4 C0 htrans", {30'd0, htrans}, need ? 32'd2 : 32'd0);
      if (need) eq("R4 C0 addr_sel", {30'd0, addr_sel}, 32'd1);
      eq("R3 dec_en", {31'd0, dec_en}, {31'd0, !i32});
      eq("R7 C0 pc_adv", {31'd0, pc_adv}, 32'd0);
      // C1
      if (need) begin
         for (int i = 0; i < waits; i++) begin
            drive(1'b0, 32'h0);
            eq("R8 C1 wait phase", {29'd0, phase}, 32'd2);
            eq("R8 C1 wait instr", instr, {16'h0, w1[31:16]});
         end
         drive(1'b1, w2);
         eq("R4 C1 phase", {29'd0, phase}, 32'd2);
         eq("R4 C1 htrans", {30'd0, htrans}, 32'd0);
      end
      // C2
      is_load  = ld;
      is_store = st;
      for (int i = 0; i <= waits; i++) begin
         drive(i == waits, 32'h0);
         eq(need ? "R2 C2 phase after C1" : "R2 C2 phase", {29'd0, phase}, 32'd3);
         eq("R5 C2 htrans", {30'd0, htrans}, (ld || st) ? 32'd2 : 32'd0);
         eq("R5 C2 hwrite", {31'd0, hwrite}, {31'd0, st});
         if (ld || st) eq("R5 C2 addr_sel", {30'd0, addr_sel}, 32'd2);
         eq("R3 R4 instr", instr, exp_i);
         eq("R3 instr_c", {31'd0, instr_c}, {31'd0, !i32});
      end
      // C3
      for (int i = 0; i <= waits; i++) begin
         drive(i == waits, 32'h0);
         eq("R2 C3 phase", {29'd0, phase}, 32'd4);
         eq("R6 C3 htrans", {30'd0, htrans}, 32'd2);
         eq("R6 C3 addr_sel", {30'd0, addr_sel}, 32'd3);
         eq("R6 C3 hwrite", {31'd0, hwrite}, 32'd0);
         eq("R6 wdata_en", {31'd0, wdata_en}, {31'd0, st});
         eq("R7 rf_we", {31'd0, rf_we}, {31'd0, (i == waits) && !st});
         eq("R7 pc_adv", {31'd0, pc_adv}, {31'd0, i == waits});
         eq("R7 pc_len4", {31'd0, pc_len4}, {31'd0, i32});
      end
      @(negedge clk);
      is_load  = 1'b0;
      is_store = 1'b0;
      hready   = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int idx;
      // R1 reset state
      repeat (3) @(negedge clk);
      #1;
      eq("R1 reset phase", {29'd0, phase}, 32'd0);
      eq("R1 reset htrans", {30'd0, htrans}, 32'd0);
      eq("R7 reset rf_we", {31'd0, rf_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      eq("R1 boot htrans", {30'd0, htrans}, 32'd2);
      eq("R1 boot addr_sel", {30'd0, addr_sel}, 32'd0);
      drive(1'b0, 32'h0);
      eq("R8 boot wait phase", {29'd0, phase}, 32'd0);
      eq("R8 boot wait htrans", {30'd0, htrans}, 32'd2);
      drive(1'b1, 32'h0);
      eq("R1 boot phase", {29'd0, phase}, 32'd0);
      eq("R7 boot pc_adv", {31'd0, pc_adv}, 32'd0);
      @(negedge clk);
      hready = 1'b0;
      // sweep alignment x width x access kind x wait states
      idx = 0;
      for (int w = 0; w < 3; w++)
         for (int ph = 0; ph < 2; ph++)
            for (int i32 = 0; i32 < 2; i32++)
               for (int op = 0; op < 3; op++) begin
                  run_instr(ph[0], i32[0], op == 1, op == 2, w,
                            32'h1357_9BDF ^ (idx * 32'h0F0F_1111));
                  idx++;
               end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule